// File: doc/BRIEF.md
# Masked Multi-Pattern Frame Matcher

This block inspects the leading bytes of every received frame and compares them against four patterns held in on-chip storage. Patterns 0 and 1 are 32 words deep and patterns 2 and 3 are 64 words deep. Each word carries two data bytes and one don't-care bit for each of them. Every pattern has its own byte count and its own enable. The block raises `accept` once any enabled pattern has matched over its full count.

Software programs the patterns and counts through an indirect write port. The port takes a 10-bit address and 18 bits of data. The even words of a pattern pair are interleaved in one region of that map. Frame bytes arrive one per cycle while `rx_valid` is high. The first byte of each frame is flagged with `rx_sof`. `accept` is a registered level. It holds until the first byte of the next frame.

Top module: `fpm_pattern_matcher`

## Requirements
- R1: After reset, `accept` is low and every pattern count is zero. No frame is accepted until a valid count has been written.
- R2: Within a pattern word, bits 7:0 hold the frame byte at the even position 2n and bits 15:8 hold the byte at the odd position 2n+1.
- R3: Word bit 16 marks the even byte as don't-care and bit 17 marks the odd byte as don't-care. A masked byte matches any frame value.
- R4: A pattern matches when frame bytes 0 to count-1 all equal the stored bytes. Bytes beyond the count have no effect on the result.
- R5: A count is valid from 2 to 32 for patterns 0 and 1, and from 2 to 64 for patterns 2 and 3. A pattern whose count is outside that range never matches.
- R6: A write to address 006h sets count 0 from data bits 7:0 and count 1 from bits 15:8. A write to 008h sets count 2 from bits 7:0 and count 3 from bits 15:8.
- R7: Word n of pattern 0 is at 280h+4n and word n of pattern 1 is at 282h+4n. Word n of pattern 2 is at 300h+4n and word n of pattern 3 is at 302h+4n.
- R8: `pat_en[i]` enables pattern i. `accept` is the OR of the matches of the enabled patterns. A pattern that is disabled when its last byte arrives does not contribute.
- R9: A frame that ends (the next `rx_sof` arrives) before a pattern's count has been reached does not match that pattern.
- R10: `accept` rises in the cycle after the clock edge that takes in the last counted byte. It stays high until the edge that takes in the next start-of-frame byte, and after that edge it is low.
- R11: Cycles with `rx_valid` low carry no byte. They leave the byte position and `accept` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 10 | Configuration word address (even) |
| cfg_wdata | input | 18 | Configuration data: two bytes plus two mask bits |
| pat_en | input | 4 | Per-pattern enable |
| rx_valid | input | 1 | Frame byte present |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_byte | input | 8 | Frame byte |
| accept | output | 1 | Frame matched at least one enabled pattern |

## Verification
The assertions assume that counts and enables do not change while a frame is inside its compare window. They also assume that `rx_sof` is only meaningful together with `rx_valid`. The stimulus rewrites counts, pattern words and enables only in idle gaps between frames. It holds `rx_sof` low on every byte except the first byte of a frame. Valid-low gaps are inserted inside frames to show that idle cycles change nothing.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 18;
  localparam int CNT_W    = 8;
  localparam int ADDR_W   = 10;
  localparam int NUM_PAT  = 4;
  localparam int POS_W    = 8;
  localparam int SMALL_DEPTH = 32;
  localparam int LARGE_DEPTH = 64;
  localparam int IDX_W    = $clog2(LARGE_DEPTH);
  localparam logic [ADDR_W-1:0] CNT01_ADDR = 10'h006;
  localparam logic [ADDR_W-1:0] CNT23_ADDR = 10'h008;

  // count lies in the legal window for a pattern of the given limit
  function automatic logic cnt_ok(input logic [CNT_W-1:0] c, input int unsigned max_c);
    return (int'(c) >= 2) && (int'(c) <= int'(max_c));
  endfunction

  // one frame byte against one half of a stored word, honouring its mask bit
  function automatic logic byte_hit(input logic [WORD_W-1:0] w, input logic odd,
                                    input logic [BYTE_W-1:0] b);
    logic             msk;
    logic [BYTE_W-1:0] d;
    msk = odd ? w[17] : w[16];
    d   = odd ? w[15:8] : w[7:0];
    return msk || (d == b);
  endfunction

  // address lands in the region shared by patterns 0 and 1
  function automatic logic in_small_region(input logic [ADDR_W-1:0] a);
    return (a[9:7] == 3'b101) && !a[0];
  endfunction

  // address lands in the region shared by patterns 2 and 3
  function automatic logic in_large_region(input logic [ADDR_W-1:0] a);
    return (a[9:8] == 2'b11) && !a[0];
  endfunction
endpackage

// File: rtl/fpm_cfg_port.sv
module fpm_cfg_port
  import fpm_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [ADDR_W-1:0]             cfg_addr,
  input  logic [WORD_W-1:0]             cfg_wdata,
  output logic [NUM_PAT-1:0]            lane_we,
  output logic [IDX_W-1:0]              lane_idx,
  output logic [NUM_PAT-1:0][CNT_W-1:0] lane_cnt
);
  logic small_hit, large_hit;

  assign small_hit = in_small_region(cfg_addr);
  assign large_hit = in_large_region(cfg_addr);
  assign lane_idx  = small_hit ? {1'b0, cfg_addr[6:2]} : cfg_addr[7:2];

  for (genvar i = 0; i < NUM_PAT; i++) begin : g_we
    localparam logic ODD = (i % 2) == 1;
    if (i < 2) begin : g_small
      assign lane_we[i] = cfg_we && small_hit && (cfg_addr[1] == ODD);
    end else begin : g_large
      assign lane_we[i] = cfg_we && large_hit && (cfg_addr[1] == ODD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_cnt <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == CNT01_ADDR) begin
        lane_cnt[0] <= cfg_wdata[7:0];
        lane_cnt[1] <= cfg_wdata[15:8];
      end else if (cfg_addr == CNT23_ADDR) begin
        lane_cnt[2] <= cfg_wdata[7:0];
        lane_cnt[3] <= cfg_wdata[15:8];
      end
    end
  end

  // R7: one address selects at most one pattern word
  p_single_lane_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_we));
endmodule

// File: rtl/fpm_lane.sv
module fpm_lane
  import fpm_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int MAX_CNT = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [CNT_W-1:0]   cnt,
  input  logic               en,
  input  logic               rx_valid,
  input  logic               rx_sof,
  input  logic [BYTE_W-1:0]  rx_byte,
  input  logic [POS_W-1:0]   pos_cur,
  output logic               hit
);
  localparam int AW = $clog2(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic              ok;
  logic              in_win, last_byte, byte_ok, ok_next, cnt_good, set_hit;
  logic [AW-1:0]     rd_idx;
  logic [WORD_W-1:0] rd_word;

  assign cnt_good  = cnt_ok(cnt, MAX_CNT);
  assign in_win    = int'(pos_cur) < int'(cnt);
  assign rd_idx    = pos_cur[AW:1];
  assign rd_word   = mem[rd_idx];
  assign byte_ok   = byte_hit(rd_word, pos_cur[0], rx_byte);
  assign ok_next   = ((pos_cur == '0) ? 1'b1 : ok) && byte_ok;
  assign last_byte = in_win && (pos_cur == cnt - 8'd1);
  assign set_hit   = rx_valid && last_byte && ok_next && cnt_good && en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok  <= 1'b0;
      hit <= 1'b0;
    end else if (rx_valid) begin
      if (in_win) ok <= ok_next;
      hit <= (hit && !rx_sof) || set_hit;
    end
  end

  // R5: a match only follows a byte taken while the count was legal
  p_hit_legal_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit) |-> $past(cnt_ok(cnt, MAX_CNT)));
  // R8: a match only follows a byte taken while the pattern was enabled
  p_hit_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit) |-> $past(en));
  // R10: a match appears only after a non-first frame byte
  p_hit_after_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit) |-> $past(rx_valid && !rx_sof));
  // R11: idle cycles leave the match flag alone
  p_idle_keeps_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(hit));
endmodule

// File: rtl/fpm_pattern_matcher.sv
module fpm_pattern_matcher
  import fpm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [9:0]  cfg_addr,
  input  logic [17:0] cfg_wdata,
  input  logic [3:0]  pat_en,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic [7:0]  rx_byte,
  output logic        accept
);
  localparam logic [POS_W-1:0] POS_IDLE = '1;

  logic [NUM_PAT-1:0]            lane_we;
  logic [IDX_W-1:0]              lane_idx;
  logic [NUM_PAT-1:0][CNT_W-1:0] lane_cnt;
  logic [NUM_PAT-1:0]            lane_hit;
  logic [POS_W-1:0]              pos, pos_cur;

  fpm_cfg_port u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .lane_we  (lane_we),
    .lane_idx (lane_idx),
    .lane_cnt (lane_cnt)
  );

  // byte position of the incoming byte; saturates at POS_IDLE outside a frame
  assign pos_cur = rx_sof ? '0 : pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= POS_IDLE;
    end else if (rx_valid) begin
      pos <= (pos_cur == POS_IDLE) ? POS_IDLE : pos_cur + 8'd1;
    end
  end

  for (genvar i = 0; i < NUM_PAT; i++) begin : g_lane
    localparam int DEP = (i < 2) ? SMALL_DEPTH : LARGE_DEPTH;
    localparam int LAW = $clog2(DEP);
    fpm_lane #(.DEPTH(DEP), .MAX_CNT(DEP)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (lane_we[i]),
      .wr_idx  (lane_idx[LAW-1:0]),
      .wr_data (cfg_wdata),
      .cnt     (lane_cnt[i]),
      .en      (pat_en[i]),
      .rx_valid(rx_valid),
      .rx_sof  (rx_sof),
      .rx_byte (rx_byte),
      .pos_cur (pos_cur),
      .hit     (lane_hit[i])
    );
  end

  assign accept = |lane_hit;

  // R10: the first byte of a frame clears any earlier accept
  p_sof_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_sof) |=> !accept);
  // R11: idle cycles leave the position counter alone
  p_idle_keeps_pos_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(pos));
  // R9: accept can rise only once a frame is at least two bytes in
  p_accept_needs_depth_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(accept) |-> (pos >= 8'd2));
endmodule

// File: tb/fpm_pattern_matcher_tb.sv
module fpm_pattern_matcher_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [9:0]  cfg_addr = '0;
  logic [17:0] cfg_wdata = '0;
  logic [3:0]  pat_en = '0;
  logic        rx_valid = 1'b0;
  logic        rx_sof = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        accept;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string cur_tag = "R1";

  // reference model state
  logic [17:0]  mpat [4][64];
  int unsigned  mcnt [4];
  byte unsigned q[$];
  bit           infrm = 0;
  bit [3:0]     mhit = '0;

  always #4 clk = ~clk;

  fpm_pattern_matcher dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pat_en(pat_en), .rx_valid(rx_valid),
    .rx_sof(rx_sof), .rx_byte(rx_byte), .accept(accept)
  );

  function automatic bit frame_fits(int p);
    int n = int'(mcnt[p]);
    for (int i = 0; i < n; i++) begin
      logic [17:0] w = mpat[p][i / 2];
      bit odd = (i % 2) == 1;
      bit msk = odd ? w[17] : w[16];
      byte unsigned d = odd ? w[15:8] : w[7:0];
      if (!msk && d != q[i]) return 0;
    end
    return 1;
  endfunction

  task automatic model_update(bit s, bit v, byte unsigned b);
    if (!v) return;
    if (s) begin q.delete(); mhit = '0; infrm = 1; end
    if (!infrm) return;
    if (q.size() < 200) q.push_back(b);
    for (int p = 0; p < 4; p++) begin
      int unsigned lim = (p < 2) ? 32 : 64;
      if (pat_en[p] && mcnt[p] >= 2 && mcnt[p] <= lim &&
          q.size() == mcnt[p] && frame_fits(p))
        mhit[p] = 1;
    end
  endtask

  task automatic compare_cycle();
    checks++;
    if (accept !== (|mhit)) begin
      fails++;
      $display("FAIL %s cycle compare: accept=%b expected=%b", cur_tag, accept, |mhit);
    end
  endtask

  task automatic expect_acc(bit e, string tag);
    checks++;
    if (accept !== e) begin
      fails++;
      $display("FAIL %s: accept=%b expected=%b", tag, accept, e);
    end
  endtask

  task automatic step(bit s, bit v, byte unsigned b);
    rx_sof = s; rx_valid = v; rx_byte = b;
    @(posedge clk);
    model_update(s, v, b);
    @(negedge clk);
    rx_sof = 0; rx_valid = 0;
    compare_cycle();
  endtask

  task automatic cfg_write(logic [9:0] a, logic [17:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 0;
    compare_cycle();
  endtask

  task automatic wr_pat(int p, int n, logic [17:0] d);
    int base = (p < 2) ? 'h280 : 'h300;
    cfg_write(10'(base + 4 * n + 2 * (p % 2)), d);
    mpat[p][n] = d;
  endtask

  task automatic set_cnt(bit upper_pair, int lo, int hi);
    cfg_write(upper_pair ? 10'h008 : 10'h006, {2'b00, 8'(hi), 8'(lo)});
    mcnt[upper_pair ? 2 : 0] = lo;
    mcnt[upper_pair ? 3 : 1] = hi;
  endtask

  task automatic send(byte unsigned f[$], bit gap);
    for (int i = 0; i < f.size(); i++) begin
      step(i == 0, 1, f[i]);
      if (gap && (i % 3) == 1) step(0, 0, 8'h5a);
    end
    step(0, 0, 0);
  endtask

  function automatic byte unsigned seq_byte(int i);
    return byte'((i * 3 + 7) % 256);
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    byte unsigned f[$];
    for (int p = 0; p < 4; p++) begin
      mcnt[p] = 0;
      for (int n = 0; n < 64; n++) mpat[p][n] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    cur_tag = "R1";
    expect_acc(0, "R1 reset state");
    pat_en = 4'hf;
    send('{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, 0);
    expect_acc(0, "R1 no valid counts after reset");

    cur_tag = "R2";
    pat_en = 4'b0001;
    wr_pat(0, 0, 18'h00002); wr_pat(0, 1, 18'h00103); wr_pat(0, 2, 18'h00204);
    set_cnt(0, 6, 4);
    step(1, 1, 8'h02); step(0, 1, 8'h00); step(0, 1, 8'h03);
    step(0, 1, 8'h01); step(0, 1, 8'h04);
    expect_acc(0, "R10 not before last counted byte");
    step(0, 1, 8'h02);
    expect_acc(1, "R2 R10 accept after last byte");
    step(0, 0, 0);
    expect_acc(1, "R10 accept held");
    step(1, 1, 8'h77);
    expect_acc(0, "R10 cleared by next sof");
    step(0, 0, 0);

    cur_tag = "R4";
    send('{8'h02, 8'h00, 8'h03, 8'h09, 8'h04, 8'h02}, 0);
    expect_acc(0, "R4 mismatch at byte 3");
    cur_tag = "R2";
    send('{8'h00, 8'h02, 8'h01, 8'h03, 8'h02, 8'h04}, 0);
    expect_acc(0, "R2 swapped byte order");
    cur_tag = "R4";
    send('{8'h02, 8'h00, 8'h03, 8'h01, 8'h04, 8'h02, 8'hff, 8'hee}, 0);
    expect_acc(1, "R4 bytes past count ignored");

    cur_tag = "R3";
    wr_pat(0, 1, 18'h20103);
    send('{8'h02, 8'h00, 8'h03, 8'h55, 8'h04, 8'h02}, 0);
    expect_acc(1, "R3 odd byte masked");
    wr_pat(0, 2, 18'h30204);
    send('{8'h02, 8'h00, 8'h03, 8'h55, 8'haa, 8'hbb}, 0);
    expect_acc(1, "R3 both bytes masked");
    send('{8'h02, 8'h00, 8'h13, 8'h55, 8'haa, 8'hbb}, 0);
    expect_acc(0, "R3 unmasked byte still compared");

    cur_tag = "R9";
    send('{8'h02, 8'h00, 8'h03, 8'h01}, 0);
    expect_acc(0, "R9 short frame");
    send('{8'h02, 8'h00, 8'h03, 8'h01, 8'h04, 8'h02}, 0);
    expect_acc(1, "R9 full frame after short one");

    cur_tag = "R5";
    pat_en = 4'b0010;
    for (int n = 0; n < 32; n++) wr_pat(1, n, 18'h00000);
    set_cnt(0, 6, 33);
    f.delete();
    for (int i = 0; i < 70; i++) f.push_back(8'h00);
    send(f, 0);
    expect_acc(0, "R5 count 33 on small pattern");
    set_cnt(0, 6, 32);
    send(f, 0);
    expect_acc(1, "R5 R7 count 32 on pattern 1");

    cur_tag = "R7";
    pat_en = 4'b1000;
    for (int n = 0; n < 32; n++)
      wr_pat(3, n, {2'b00, seq_byte(2 * n + 1), seq_byte(2 * n)});
    set_cnt(1, 1, 64);
    f.delete();
    for (int i = 0; i < 66; i++) f.push_back(seq_byte(i));
    send(f, 1);
    expect_acc(1, "R5 R7 R11 pattern 3 count 64 with gaps");
    f[63] = f[63] ^ 8'h01;
    send(f, 1);
    expect_acc(0, "R4 pattern 3 last byte differs");

    cur_tag = "R6";
    pat_en = 4'b0100;
    f.delete();
    for (int i = 0; i < 8; i++) f.push_back(8'h00);
    send(f, 0);
    expect_acc(0, "R5 R6 count 2 is 1 (invalid)");
    set_cnt(1, 2, 64);
    send(f, 0);
    expect_acc(1, "R6 count 2 from low byte");

    cur_tag = "R8";
    pat_en = 4'b0000;
    send('{8'h02, 8'h00, 8'h03, 8'h01, 8'h04, 8'h02}, 0);
    expect_acc(0, "R8 all disabled");
    pat_en = 4'b1001;
    send('{8'h02, 8'h00, 8'h03, 8'h01, 8'h04, 8'h02}, 0);
    expect_acc(1, "R8 pattern 0 of two enabled");
    f.delete();
    for (int i = 0; i < 64; i++) f.push_back(seq_byte(i));
    send(f, 0);
    expect_acc(1, "R8 pattern 3 of two enabled");

    repeat (3) step(0, 0, 0);
    done = 1;
    finish_run();
  end
endmodule